// File: doc/BRIEF.md
# Reloadable Periodic Tick Timer

This block is a per-processor periodic timer that produces the clock interrupt request. Software loads it with an interval and a separate initial time-left, both counted in microsecond ticks. The first expiry comes after the time-left. Every later expiry comes one full interval after the one before. Each expiry gives a one-cycle raise pulse and advances an expiry counter. The time still remaining is always readable, so a save/restore routine can capture the timer and bring it back later by reinstalling it with the saved interval and the remaining time.

The control path is a three-state machine:
- `TT_IDLE`: the timer is stopped.
- `TT_FIRST`: counting down the initial time-left.
- `TT_PERIODIC`: counting down full intervals.

Its transitions are:
- `install_go`: an install with a nonzero interval, taken from any state, goes to `TT_FIRST`.
- `install_stop`: an install with a zero interval, taken from any state, goes to `TT_IDLE`.
- `first_expire`: `TT_FIRST` to `TT_PERIODIC`.
- `period_expire`: `TT_PERIODIC` back to itself.

An install always replaces whatever expiry was pending.

Top module: `tick_timer`

## Requirements
- R1: After reset, `clk_raise` is 0, `started` is 0, `remaining` is 0 and `expiry_count` is 0.
- R2: An install strobe with a nonzero interval is sampled at a clock edge. From the next cycle, `started` is 1, the interval is stored, and the countdown is loaded with the time-left. No raise pulse appears in that cycle.
- R3: After an install, the first expiry happens on the clock edge that samples the max(time-left,1)-th asserted `us_tick`. `clk_raise` is high in the cycle after that edge.
- R4: After any expiry, the next expiry happens on the edge that samples the interval-th following asserted `us_tick`.
- R5: On cycles where `us_tick` is low and no install is sampled, `remaining`, `started` and `expiry_count` do not change, and no raise follows.
- R6: An install while the timer is running cancels the pending expiry. If an install and a tick are sampled at the same edge, the install wins and the tick is not counted.
- R7: `remaining` equals the ticks left before the next expiry, limited to never exceed the stored interval.
- R8: An install with interval 0 stops the timer. `started` goes to 0, no further raise pulses occur, and `remaining` reads 0.
- R9: `expiry_count` increases by exactly one, modulo 2^32, with every raise pulse and never otherwise.
- R10: Reinstalling with a stored interval and a previously read `remaining` value resumes the same expiry schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| install | input | 1 | Install strobe, one cycle |
| install_interval | input | 32 | Period in ticks; 0 stops the timer |
| install_left | input | 32 | Ticks until the first expiry |
| us_tick | input | 1 | Microsecond tick enable |
| clk_raise | output | 1 | Clock interrupt raise pulse |
| started | output | 1 | Timer is running |
| remaining | output | 32 | Clamped ticks to next expiry |
| expiry_count | output | 32 | Number of expiries, wrapping |

## Verification
The schedule is tried with ticks on every cycle, ticks on every third cycle, and tick bursts broken by idle gaps. Comparing these shows whether the countdown follows ticks or clock cycles. Time-left values below, equal to and above the interval separate the first-expiry path from the periodic reload and exercise the readback clamp. Reinstalls are placed mid-countdown and on the same edge as a tick, which shows cancellation and install priority. A save-and-resume install checks that the schedule carries on, and an interval of 1 with constant ticks checks back-to-back expiries.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    typedef enum logic [1:0] {
        TT_IDLE     = 2'd0,
        TT_FIRST    = 2'd1,
        TT_PERIODIC = 2'd2
    } tt_state_e;
endpackage

// File: rtl/tick_timer_fsm.sv
module tick_timer_fsm
    import tick_timer_pkg::*;
#(
    parameter int EVT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             install,
    input  logic             iv_zero,
    input  logic             us_tick,
    input  logic             at_end,
    output tt_state_e        state,
    output logic             expire,
    output logic             raise,
    output logic [EVT_W-1:0] evt_count
);
    tt_state_e state_nx;

    assign expire = (state != TT_IDLE) && us_tick && at_end && !install;

    always_comb begin
        state_nx = state;
        unique case (state)
            TT_IDLE:     if (install) state_nx = iv_zero ? TT_IDLE : TT_FIRST;
            TT_FIRST:    if (install) state_nx = iv_zero ? TT_IDLE : TT_FIRST;
                         else if (expire) state_nx = TT_PERIODIC;
            TT_PERIODIC: if (install) state_nx = iv_zero ? TT_IDLE : TT_FIRST;
            default:     state_nx = TT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TT_IDLE;
        else        state <= state_nx;
    end

    // outputs: raise pulse and event counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raise     <= 1'b0;
            evt_count <= '0;
        end else begin
            raise <= expire;
            if (expire) evt_count <= evt_count + 1'b1;
        end
    end

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TT_IDLE) |=> !raise); // R8
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        raise |-> (evt_count == EVT_W'($past(evt_count) + 1'b1))); // R9
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !raise |-> $stable(evt_count)); // R9
endmodule

// File: rtl/tick_timer_down.sv
module tick_timer_down #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] left,
    output logic             at_end
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign at_end = (left <= ONE);

    always_ff @(posedge clk) begin
        if (!rst_n)   left <= '0;
        else if (load) left <= load_val;
        else if (dec && !at_end) left <= left - ONE;
    end
endmodule

// File: rtl/tick_timer_clamp.sv
module tick_timer_clamp #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] left,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] shown
);
    always_comb shown = (left > limit) ? limit : left;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int EVT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             install,
    input  logic [CNT_W-1:0] install_interval,
    input  logic [CNT_W-1:0] install_left,
    input  logic             us_tick,
    output logic             clk_raise,
    output logic             started,
    output logic [CNT_W-1:0] remaining,
    output logic [EVT_W-1:0] expiry_count
);
    tt_state_e        state;
    logic             expire;
    logic             at_end;
    logic [CNT_W-1:0] interval_q;
    logic [CNT_W-1:0] left;
    logic [CNT_W-1:0] load_val;

    always_ff @(posedge clk) begin
        if (!rst_n)       interval_q <= '0;
        else if (install) interval_q <= install_interval;
    end

    assign started  = (state != TT_IDLE);
    assign load_val = install ? install_left : interval_q;

    tick_timer_fsm #(.EVT_W(EVT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .install   (install),
        .iv_zero   (install_interval == '0),
        .us_tick   (us_tick),
        .at_end    (at_end),
        .state     (state),
        .expire    (expire),
        .raise     (clk_raise),
        .evt_count (expiry_count)
    );

    tick_timer_down #(.CNT_W(CNT_W)) u_down (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (install || expire),
        .load_val (load_val),
        .dec      (us_tick && started),
        .left     (left),
        .at_end   (at_end)
    );

    tick_timer_clamp #(.CNT_W(CNT_W)) u_clamp (
        .left  (left),
        .limit (interval_q),
        .shown (remaining)
    );

    AST_INSTALL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (install && install_interval != '0) |=> (started && !clk_raise)); // R2
    AST_INSTALL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (install && install_interval == '0) |=> (!started && remaining == '0)); // R8
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!install && !us_tick) |=> ($stable(remaining) && $stable(started) && !clk_raise)); // R5
    AST_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        remaining <= interval_q); // R7
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        install = 1'b0;
    logic [31:0] install_interval = '0;
    logic [31:0] install_left = '0;
    logic        us_tick = 1'b0;
    logic        clk_raise;
    logic        started;
    logic [31:0] remaining;
    logic [31:0] expiry_count;

    int applied = 0;
    int failed  = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit          m_started = 0;
    longint      m_iv = 0;
    longint      m_left = 0;
    bit          m_raise = 0;
    int unsigned m_cnt = 0;

    always #4 clk = ~clk; // 125 MHz

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .install(install),
        .install_interval(install_interval), .install_left(install_left),
        .us_tick(us_tick), .clk_raise(clk_raise), .started(started),
        .remaining(remaining), .expiry_count(expiry_count)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 0; m_iv = 0; m_left = 0; m_raise = 0; m_cnt = 0;
        end else if (install) begin
            m_iv = install_interval; m_left = install_left;
            m_started = (install_interval != 0); m_raise = 0;
        end else if (m_started && us_tick) begin
            if (m_left <= 1) begin
                m_raise = 1; m_cnt++; m_left = m_iv;
            end else begin
                m_raise = 0; m_left--;
            end
        end else begin
            m_raise = 0;
        end
    end

    always @(posedge clk) begin
        longint exp_rem;
        #2;
        exp_rem = (m_left > m_iv) ? m_iv : m_left;
        applied++;
        if (clk_raise !== m_raise || started !== m_started ||
            remaining !== 32'(exp_rem) || expiry_count !== m_cnt) begin
            failed++;
            $display("FAIL %s: raise/started/remaining/count = %0b/%0b/%0d/%0d expected %0b/%0b/%0d/%0d",
                     cur_req, clk_raise, started, remaining, expiry_count,
                     m_raise, m_started, exp_rem, m_cnt);
        end
    end

    task automatic drive(input bit ins, input int iv, input int tl, input bit tk);
        @(negedge clk);
        install = ins; install_interval = iv; install_left = tl; us_tick = tk;
    endtask

    task automatic run(input int n, input int every);
        for (int i = 0; i < n; i++) drive(0, 0, 0, (i % every) == 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        int seen;
        int saved_iv, saved_rem;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(0, 0, 0, 1);

        // R2 / R3: first expiry after time-left, directed count
        cur_req = "R3";
        drive(1, 5, 3, 0);
        seen = 0;
        for (int k = 1; k <= 10; k++) begin
            drive(0, 0, 0, 1);
            @(posedge clk); #1;
            if (clk_raise && seen == 0) seen = k;
        end
        applied++;
        if (seen != 3) begin
            failed++;
            $display("FAIL R3: first raise after %0d ticks expected %0d", seen, 3);
        end

        // R4: periodic with ticks every cycle
        cur_req = "R4";
        run(25, 1);
        // R5: sparse ticks
        cur_req = "R5";
        run(40, 3);
        // R6: reinstall mid countdown, then install on the same edge as a tick
        cur_req = "R6";
        drive(1, 4, 7, 0);
        run(3, 1);
        drive(1, 6, 2, 1);
        run(20, 1);
        // R7: time-left larger than interval
        cur_req = "R7";
        drive(1, 6, 20, 0);
        run(30, 2);
        // R10: save remaining and resume
        cur_req = "R10";
        run(3, 1);
        drive(0, 0, 0, 0);
        @(posedge clk); #1;
        saved_iv = 6; saved_rem = remaining;
        drive(1, saved_iv, saved_rem, 0);
        run(20, 1);
        // R3: time-left of 0
        cur_req = "R3";
        drive(1, 3, 0, 0);
        run(10, 1);
        // R9: interval 1, back-to-back expiries
        cur_req = "R9";
        drive(1, 1, 1, 0);
        run(15, 1);
        // R8: stop
        cur_req = "R8";
        drive(1, 0, 9, 1);
        run(15, 1);
        // R2: restart after stop, with gaps
        cur_req = "R2";
        drive(1, 2, 5, 0);
        run(20, 4);
        drive(0, 0, 0, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule